// File: doc/BRIEF.md
# Multi-mode test loopback router

This block steers the data paths of a basic-rate line controller for test. It sits between three neighbours. The first is the layer-2 HDLC transmitter and receiver. The second is the PCM port inputs and outputs. The third is the layer-1 line transmitter and receiver. B1 and B2 are carried as bytes and D as single bits. A strobe marks each one, and a frame strobe marks each frame. Two control bits select a digital loop or a remote loop. The remote loop takes priority, so the two loops can never be active together.

In digital loop the block switches to an internal frame timing generator. It returns HDLC transmit data to the HDLC receiver and PCM input data to the PCM outputs. The line transmitter is held idle. In remote loop the B channels recovered from the line are sent back out to the line. D stays on its normal path in both directions. A mode change is committed only on a frame strobe of the timing that is active at that moment, so no frame mixes looped and unlooped data.

A separate analog-loop command gates off the line output and requests an internal line loop. It also drives a 4-bit indication from two inputs: the receiver-lock flag and the awake-level detector.

Top module: `test_loop_router`

## Requirements
- R1: In digital mode, the HDLC receive outputs B1, B2 and D take the values on the HDLC transmit inputs at the matching internal strobe. Each output is visible one cycle after its strobe.
- R2: In digital mode, the PCM outputs B1 and B2 take the PCM input values at the internal B1 and B2 strobes, one cycle later.
- R3: In digital mode, the strobe outputs follow the internal generator, delayed one cycle. With a frame length of F clock cycles, the generator places the frame strobe at count 0, B1 at F/8, D at 3F/8 and 7F/8, and B2 at F/2. Line strobes do not affect the strobe outputs in this mode. At each line strobe the line transmit outputs load the idle value: all ones for B and 1 for D.
- R4: In remote mode, at each line B strobe, the line transmit B1 and B2 outputs load the line receive B1 and B2 values.
- R5: In remote mode, at each line D strobe, the line transmit D output loads the HDLC transmit D. The HDLC receive D output loads the line receive D.
- R6: While the remote request is set, the digital request has no effect. The mode committed at a boundary is remote.
- R7: The mode is committed only on a frame strobe of the active timing: the internal frame in digital mode, otherwise the line frame. The committed mode is remote if the remote request is set, else digital if the digital request is set, else normal.
- R8: In normal mode, the line transmit B and D outputs load the HDLC transmit values at line strobes. The HDLC receive outputs and the PCM outputs load the line receive values at line strobes. The strobe outputs follow the line strobes, delayed one cycle.
- R9: One cycle after the analog-loop command is raised, al_loop_o is 1 and l1_tx_en_o is 0. One cycle after the command is removed, the two outputs return to 0 and 1.
- R10: ind_o is registered with one cycle of latency. It reads 4'h0 (normal) when the analog-loop command is low. With the command high it reads 4'hB (awake-test) if the awake detector is set, else 4'h8 (test) if the receiver is locked, else 4'h0.
- R11: After reset the mode is normal. All strobe outputs are 0, B data outputs are all ones, D outputs are 1, ind_o is 4'h0, al_loop_o is 0 and l1_tx_en_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dig_loop_i | input | 1 | Digital loop request bit |
| rem_loop_i | input | 1 | Remote loop request bit |
| ana_loop_cmd_i | input | 1 | Analog loop command |
| rx_lock_i | input | 1 | Line receiver locked |
| awake_det_i | input | 1 | External awake level detected |
| l1_frame_i | input | 1 | Line frame strobe |
| l1_b1_stb_i | input | 1 | Line B1 strobe |
| l1_b2_stb_i | input | 1 | Line B2 strobe |
| l1_d_stb_i | input | 1 | Line D bit strobe |
| l1_rx_b1_i | input | B_W | Line receive B1 |
| l1_rx_b2_i | input | B_W | Line receive B2 |
| l1_rx_d_i | input | 1 | Line receive D bit |
| hdlc_tx_b1_i | input | B_W | HDLC transmit B1 |
| hdlc_tx_b2_i | input | B_W | HDLC transmit B2 |
| hdlc_tx_d_i | input | 1 | HDLC transmit D bit |
| pcm_in_b1_i | input | B_W | PCM input B1 |
| pcm_in_b2_i | input | B_W | PCM input B2 |
| frame_o | output | 1 | Frame strobe of active timing |
| b1_stb_o | output | 1 | B1 strobe of active timing |
| b2_stb_o | output | 1 | B2 strobe of active timing |
| d_stb_o | output | 1 | D strobe of active timing |
| hdlc_rx_b1_o | output | B_W | HDLC receive B1 |
| hdlc_rx_b2_o | output | B_W | HDLC receive B2 |
| hdlc_rx_d_o | output | 1 | HDLC receive D bit |
| pcm_out_b1_o | output | B_W | PCM output B1 |
| pcm_out_b2_o | output | B_W | PCM output B2 |
| l1_tx_b1_o | output | B_W | Line transmit B1 |
| l1_tx_b2_o | output | B_W | Line transmit B2 |
| l1_tx_d_o | output | 1 | Line transmit D bit |
| l1_tx_en_o | output | 1 | Line output enable |
| al_loop_o | output | 1 | Internal analog loop request |
| ind_o | output | 4 | Loop status indication |

## Verification
The bench builds the block with FRAME_CYCLES = 32 and the default 8-bit channel width. With a 32-cycle internal frame running against a 40-cycle line frame, the two timings drift past each other. Mode entries and exits then fall at many different phases within a few thousand cycles. Short request pulses that start and end inside a frame, and a remote request laid over an active digital request, are both reached within a handful of frames.

// File: rtl/loop_rtr_pkg.sv
package loop_rtr_pkg;
  typedef enum logic [1:0] {
    M_NORMAL  = 2'd0,
    M_DIGITAL = 2'd1,
    M_REMOTE  = 2'd2
  } loop_mode_e;

  localparam logic [3:0] IND_NORMAL = 4'h0;
  localparam logic [3:0] IND_TEST   = 4'h8;
  localparam logic [3:0] IND_AWAKE  = 4'hB;
endpackage

// File: rtl/loop_rtr_timing_gen.sv
module loop_rtr_timing_gen #(
  parameter int FRAME_CYCLES = 6250
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic frame_o,
  output logic b1_stb_o,
  output logic b2_stb_o,
  output logic d_stb_o
);
  localparam int CW     = $clog2(FRAME_CYCLES);
  localparam int B1_OFS = FRAME_CYCLES / 8;
  localparam int D0_OFS = (FRAME_CYCLES * 3) / 8;
  localparam int B2_OFS = FRAME_CYCLES / 2;
  localparam int D1_OFS = (FRAME_CYCLES * 7) / 8;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (cnt_q == CW'(FRAME_CYCLES - 1)) cnt_q <= '0;
    else                                     cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    frame_o  = (cnt_q == '0);
    b1_stb_o = (cnt_q == CW'(B1_OFS));
    b2_stb_o = (cnt_q == CW'(B2_OFS));
    d_stb_o  = (cnt_q == CW'(D0_OFS)) || (cnt_q == CW'(D1_OFS));
  end
endmodule

// File: rtl/loop_rtr_mode_ctrl.sv
module loop_rtr_mode_ctrl
  import loop_rtr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dig_loop_i,
  input  logic       rem_loop_i,
  input  logic       boundary_i,
  input  logic       ana_loop_cmd_i,
  input  logic       rx_lock_i,
  input  logic       awake_det_i,
  output loop_mode_e mode_o,
  output logic       al_loop_o,
  output logic [3:0] ind_o
);
  loop_mode_e mode_d;
  logic [3:0] ind_d;

  // remote request masks digital request
  always_comb begin
    if (rem_loop_i)      mode_d = M_REMOTE;
    else if (dig_loop_i) mode_d = M_DIGITAL;
    else                 mode_d = M_NORMAL;
  end

  always_comb begin
    if (!ana_loop_cmd_i)  ind_d = IND_NORMAL;
    else if (awake_det_i) ind_d = IND_AWAKE;
    else if (rx_lock_i)   ind_d = IND_TEST;
    else                  ind_d = IND_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= M_NORMAL;
      al_loop_o <= 1'b0;
      ind_o     <= IND_NORMAL;
    end else begin
      if (boundary_i) mode_o <= mode_d;
      al_loop_o <= ana_loop_cmd_i;
      ind_o     <= ind_d;
    end
  end
endmodule

// File: rtl/loop_rtr_data_mux.sv
module loop_rtr_data_mux
  import loop_rtr_pkg::*;
#(
  parameter int B_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  loop_mode_e     mode_i,
  input  logic           sel_frame_i,
  input  logic           sel_b1_i,
  input  logic           sel_b2_i,
  input  logic           sel_d_i,
  input  logic           l1_b1_stb_i,
  input  logic           l1_b2_stb_i,
  input  logic           l1_d_stb_i,
  input  logic [B_W-1:0] l1_rx_b1_i,
  input  logic [B_W-1:0] l1_rx_b2_i,
  input  logic           l1_rx_d_i,
  input  logic [B_W-1:0] hdlc_tx_b1_i,
  input  logic [B_W-1:0] hdlc_tx_b2_i,
  input  logic           hdlc_tx_d_i,
  input  logic [B_W-1:0] pcm_in_b1_i,
  input  logic [B_W-1:0] pcm_in_b2_i,
  output logic           frame_o,
  output logic           b1_stb_o,
  output logic           b2_stb_o,
  output logic           d_stb_o,
  output logic [B_W-1:0] hdlc_rx_b1_o,
  output logic [B_W-1:0] hdlc_rx_b2_o,
  output logic           hdlc_rx_d_o,
  output logic [B_W-1:0] pcm_out_b1_o,
  output logic [B_W-1:0] pcm_out_b2_o,
  output logic [B_W-1:0] l1_tx_b1_o,
  output logic [B_W-1:0] l1_tx_b2_o,
  output logic           l1_tx_d_o
);
  localparam logic [B_W-1:0] B_IDLE = {B_W{1'b1}};

  logic [B_W-1:0] rx_b1_src, rx_b2_src, pcm_b1_src, pcm_b2_src;
  logic [B_W-1:0] tx_b1_src, tx_b2_src;
  logic           rx_d_src, tx_d_src;

  always_comb begin
    rx_b1_src  = l1_rx_b1_i;
    rx_b2_src  = l1_rx_b2_i;
    rx_d_src   = l1_rx_d_i;
    pcm_b1_src = l1_rx_b1_i;
    pcm_b2_src = l1_rx_b2_i;
    tx_b1_src  = hdlc_tx_b1_i;
    tx_b2_src  = hdlc_tx_b2_i;
    tx_d_src   = hdlc_tx_d_i;
    unique case (mode_i)
      M_DIGITAL: begin
        rx_b1_src  = hdlc_tx_b1_i;
        rx_b2_src  = hdlc_tx_b2_i;
        rx_d_src   = hdlc_tx_d_i;
        pcm_b1_src = pcm_in_b1_i;
        pcm_b2_src = pcm_in_b2_i;
        tx_b1_src  = B_IDLE;
        tx_b2_src  = B_IDLE;
        tx_d_src   = 1'b1;
      end
      M_REMOTE: begin
        // only B returns to the line; D keeps its normal path
        tx_b1_src = l1_rx_b1_i;
        tx_b2_src = l1_rx_b2_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o      <= 1'b0;
      b1_stb_o     <= 1'b0;
      b2_stb_o     <= 1'b0;
      d_stb_o      <= 1'b0;
      hdlc_rx_b1_o <= B_IDLE;
      hdlc_rx_b2_o <= B_IDLE;
      hdlc_rx_d_o  <= 1'b1;
      pcm_out_b1_o <= B_IDLE;
      pcm_out_b2_o <= B_IDLE;
    end else begin
      frame_o  <= sel_frame_i;
      b1_stb_o <= sel_b1_i;
      b2_stb_o <= sel_b2_i;
      d_stb_o  <= sel_d_i;
      if (sel_b1_i) begin
        hdlc_rx_b1_o <= rx_b1_src;
        pcm_out_b1_o <= pcm_b1_src;
      end
      if (sel_b2_i) begin
        hdlc_rx_b2_o <= rx_b2_src;
        pcm_out_b2_o <= pcm_b2_src;
      end
      if (sel_d_i) hdlc_rx_d_o <= rx_d_src;
    end
  end

  // line transmitter always runs on line timing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_tx_b1_o <= B_IDLE;
      l1_tx_b2_o <= B_IDLE;
      l1_tx_d_o  <= 1'b1;
    end else begin
      if (l1_b1_stb_i) l1_tx_b1_o <= tx_b1_src;
      if (l1_b2_stb_i) l1_tx_b2_o <= tx_b2_src;
      if (l1_d_stb_i)  l1_tx_d_o  <= tx_d_src;
    end
  end
endmodule

// File: rtl/test_loop_router.sv
module test_loop_router
  import loop_rtr_pkg::*;
#(
  parameter int FRAME_CYCLES = 6250,
  parameter int B_W          = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           dig_loop_i,
  input  logic           rem_loop_i,
  input  logic           ana_loop_cmd_i,
  input  logic           rx_lock_i,
  input  logic           awake_det_i,
  input  logic           l1_frame_i,
  input  logic           l1_b1_stb_i,
  input  logic           l1_b2_stb_i,
  input  logic           l1_d_stb_i,
  input  logic [B_W-1:0] l1_rx_b1_i,
  input  logic [B_W-1:0] l1_rx_b2_i,
  input  logic           l1_rx_d_i,
  input  logic [B_W-1:0] hdlc_tx_b1_i,
  input  logic [B_W-1:0] hdlc_tx_b2_i,
  input  logic           hdlc_tx_d_i,
  input  logic [B_W-1:0] pcm_in_b1_i,
  input  logic [B_W-1:0] pcm_in_b2_i,
  output logic           frame_o,
  output logic           b1_stb_o,
  output logic           b2_stb_o,
  output logic           d_stb_o,
  output logic [B_W-1:0] hdlc_rx_b1_o,
  output logic [B_W-1:0] hdlc_rx_b2_o,
  output logic           hdlc_rx_d_o,
  output logic [B_W-1:0] pcm_out_b1_o,
  output logic [B_W-1:0] pcm_out_b2_o,
  output logic [B_W-1:0] l1_tx_b1_o,
  output logic [B_W-1:0] l1_tx_b2_o,
  output logic           l1_tx_d_o,
  output logic           l1_tx_en_o,
  output logic           al_loop_o,
  output logic [3:0]     ind_o
);
  logic       int_frame, int_b1, int_b2, int_d;
  logic       sel_frame, sel_b1, sel_b2, sel_d;
  loop_mode_e mode_q;

  loop_rtr_timing_gen #(.FRAME_CYCLES(FRAME_CYCLES)) u_tgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_o  (int_frame),
    .b1_stb_o (int_b1),
    .b2_stb_o (int_b2),
    .d_stb_o  (int_d)
  );

  always_comb begin
    if (mode_q == M_DIGITAL) begin
      sel_frame = int_frame;
      sel_b1    = int_b1;
      sel_b2    = int_b2;
      sel_d     = int_d;
    end else begin
      sel_frame = l1_frame_i;
      sel_b1    = l1_b1_stb_i;
      sel_b2    = l1_b2_stb_i;
      sel_d     = l1_d_stb_i;
    end
  end

  loop_rtr_mode_ctrl u_mode (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .dig_loop_i     (dig_loop_i),
    .rem_loop_i     (rem_loop_i),
    .boundary_i     (sel_frame),
    .ana_loop_cmd_i (ana_loop_cmd_i),
    .rx_lock_i      (rx_lock_i),
    .awake_det_i    (awake_det_i),
    .mode_o         (mode_q),
    .al_loop_o      (al_loop_o),
    .ind_o          (ind_o)
  );

  assign l1_tx_en_o = ~al_loop_o;

  loop_rtr_data_mux #(.B_W(B_W)) u_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_q),
    .sel_frame_i  (sel_frame),
    .sel_b1_i     (sel_b1),
    .sel_b2_i     (sel_b2),
    .sel_d_i      (sel_d),
    .l1_b1_stb_i  (l1_b1_stb_i),
    .l1_b2_stb_i  (l1_b2_stb_i),
    .l1_d_stb_i   (l1_d_stb_i),
    .l1_rx_b1_i   (l1_rx_b1_i),
    .l1_rx_b2_i   (l1_rx_b2_i),
    .l1_rx_d_i    (l1_rx_d_i),
    .hdlc_tx_b1_i (hdlc_tx_b1_i),
    .hdlc_tx_b2_i (hdlc_tx_b2_i),
    .hdlc_tx_d_i  (hdlc_tx_d_i),
    .pcm_in_b1_i  (pcm_in_b1_i),
    .pcm_in_b2_i  (pcm_in_b2_i),
    .frame_o      (frame_o),
    .b1_stb_o     (b1_stb_o),
    .b2_stb_o     (b2_stb_o),
    .d_stb_o      (d_stb_o),
    .hdlc_rx_b1_o (hdlc_rx_b1_o),
    .hdlc_rx_b2_o (hdlc_rx_b2_o),
    .hdlc_rx_d_o  (hdlc_rx_d_o),
    .pcm_out_b1_o (pcm_out_b1_o),
    .pcm_out_b2_o (pcm_out_b2_o),
    .l1_tx_b1_o   (l1_tx_b1_o),
    .l1_tx_b2_o   (l1_tx_b2_o),
    .l1_tx_d_o    (l1_tx_d_o)
  );
endmodule

// File: rtl/loop_rtr_chk.sv
module loop_rtr_chk
  import loop_rtr_pkg::*;
#(
  parameter int B_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input loop_mode_e     mode_q,
  input logic           sel_frame,
  input logic           sel_b1,
  input logic           sel_d,
  input logic           rem_loop_i,
  input logic           ana_loop_cmd_i,
  input logic           l1_b1_stb_i,
  input logic [B_W-1:0] l1_rx_b1_i,
  input logic           hdlc_tx_d_i,
  input logic [B_W-1:0] pcm_in_b1_i,
  input logic           hdlc_rx_d_o,
  input logic [B_W-1:0] pcm_out_b1_o,
  input logic [B_W-1:0] l1_tx_b1_o,
  input logic           l1_tx_en_o,
  input logic           al_loop_o,
  input logic [3:0]     ind_o
);
  // R1
  dig_d_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_DIGITAL && sel_d) |=> (hdlc_rx_d_o == $past(hdlc_tx_d_i)));
  // R2
  dig_pcm_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_DIGITAL && sel_b1) |=> (pcm_out_b1_o == $past(pcm_in_b1_i)));
  // R3
  dig_tx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_DIGITAL && l1_b1_stb_i) |=> (l1_tx_b1_o == {B_W{1'b1}}));
  // R4
  rem_b_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_REMOTE && l1_b1_stb_i) |=> (l1_tx_b1_o == $past(l1_rx_b1_i)));
  // R6
  rem_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_loop_i && sel_frame) |=> (mode_q == M_REMOTE));
  // R7
  mode_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_frame |=> $stable(mode_q));
  // R9
  ana_tx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ana_loop_cmd_i |=> (!l1_tx_en_o && al_loop_o));
  // R10
  ind_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !al_loop_o |-> (ind_o == IND_NORMAL));
endmodule

bind test_loop_router loop_rtr_chk #(.B_W(B_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_q         (mode_q),
  .sel_frame      (sel_frame),
  .sel_b1         (sel_b1),
  .sel_d          (sel_d),
  .rem_loop_i     (rem_loop_i),
  .ana_loop_cmd_i (ana_loop_cmd_i),
  .l1_b1_stb_i    (l1_b1_stb_i),
  .l1_rx_b1_i     (l1_rx_b1_i),
  .hdlc_tx_d_i    (hdlc_tx_d_i),
  .pcm_in_b1_i    (pcm_in_b1_i),
  .hdlc_rx_d_o    (hdlc_rx_d_o),
  .pcm_out_b1_o   (pcm_out_b1_o),
  .l1_tx_b1_o     (l1_tx_b1_o),
  .l1_tx_en_o     (l1_tx_en_o),
  .al_loop_o      (al_loop_o),
  .ind_o          (ind_o)
);

// File: tb/test_loop_router_tb_top.sv
`timescale 1ns/1ps
module test_loop_router_tb_top;
  localparam int F   = 32;
  localparam int LP  = 40;
  localparam int B_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic dig = 0, rem = 0, ana = 0, lock = 0, awake = 0;
  logic l1f = 0, l1b1 = 0, l1b2 = 0, l1d = 0;
  logic [B_W-1:0] rxb1 = 0, rxb2 = 0, txb1 = 0, txb2 = 0, pb1 = 0, pb2 = 0;
  logic rxd = 0, txd = 0;

  logic fo, b1o, b2o, dso, hrd, trd, ten, alo;
  logic [B_W-1:0] hrb1, hrb2, pob1, pob2, tb1, tb2;
  logic [3:0] ind;

  test_loop_router #(.FRAME_CYCLES(F), .B_W(B_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dig_loop_i(dig), .rem_loop_i(rem),
    .ana_loop_cmd_i(ana), .rx_lock_i(lock), .awake_det_i(awake),
    .l1_frame_i(l1f), .l1_b1_stb_i(l1b1), .l1_b2_stb_i(l1b2), .l1_d_stb_i(l1d),
    .l1_rx_b1_i(rxb1), .l1_rx_b2_i(rxb2), .l1_rx_d_i(rxd),
    .hdlc_tx_b1_i(txb1), .hdlc_tx_b2_i(txb2), .hdlc_tx_d_i(txd),
    .pcm_in_b1_i(pb1), .pcm_in_b2_i(pb2),
    .frame_o(fo), .b1_stb_o(b1o), .b2_stb_o(b2o), .d_stb_o(dso),
    .hdlc_rx_b1_o(hrb1), .hdlc_rx_b2_o(hrb2), .hdlc_rx_d_o(hrd),
    .pcm_out_b1_o(pob1), .pcm_out_b2_o(pob2),
    .l1_tx_b1_o(tb1), .l1_tx_b2_o(tb2), .l1_tx_d_o(trd),
    .l1_tx_en_o(ten), .al_loop_o(alo), .ind_o(ind)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model: 0 normal, 1 digital, 2 remote
  int m_mode, m_cnt;
  int e_fo, e_b1o, e_b2o, e_dso, e_hrb1, e_hrb2, e_hrd, e_pob1, e_pob2;
  int e_tb1, e_tb2, e_trd, e_al, e_ind;

  task automatic model_reset();
    m_mode = 0; m_cnt = 0;
    e_fo = 0; e_b1o = 0; e_b2o = 0; e_dso = 0;
    e_hrb1 = 255; e_hrb2 = 255; e_hrd = 1; e_pob1 = 255; e_pob2 = 255;
    e_tb1 = 255; e_tb2 = 255; e_trd = 1; e_al = 0; e_ind = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit sf, s1, s2, sd;
      if (m_mode == 1) begin
        sf = (m_cnt == 0); s1 = (m_cnt == F/8); s2 = (m_cnt == F/2);
        sd = (m_cnt == 3*F/8) || (m_cnt == 7*F/8);
      end else begin
        sf = l1f; s1 = l1b1; s2 = l1b2; sd = l1d;
      end
      e_fo = sf; e_b1o = s1; e_b2o = s2; e_dso = sd;
      if (s1) begin
        e_hrb1 = (m_mode == 1) ? txb1 : rxb1;
        e_pob1 = (m_mode == 1) ? pb1 : rxb1;
      end
      if (s2) begin
        e_hrb2 = (m_mode == 1) ? txb2 : rxb2;
        e_pob2 = (m_mode == 1) ? pb2 : rxb2;
      end
      if (sd) e_hrd = (m_mode == 1) ? txd : rxd;
      if (l1b1) e_tb1 = (m_mode == 1) ? 255 : (m_mode == 2) ? rxb1 : txb1;
      if (l1b2) e_tb2 = (m_mode == 1) ? 255 : (m_mode == 2) ? rxb2 : txb2;
      if (l1d)  e_trd = (m_mode == 1) ? 1 : txd;
      if (sf) m_mode = rem ? 2 : (dig ? 1 : 0);
      e_al = ana;
      e_ind = !ana ? 0 : awake ? 11 : lock ? 8 : 0;
      m_cnt = (m_cnt == F-1) ? 0 : m_cnt + 1;
    end
  end

  function automatic string dtag(int md);
    return (md == 1) ? "R1" : (md == 2) ? "R5" : "R8";
  endfunction

  task automatic chk(string tag, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string bt;
    bt = (m_mode == 1) ? "R3" : "R8";
    chk(bt, "frame_o", fo, e_fo);
    chk(bt, "b1_stb_o", b1o, e_b1o);
    chk(bt, "b2_stb_o", b2o, e_b2o);
    chk(bt, "d_stb_o", dso, e_dso);
    chk(dtag(m_mode), "hdlc_rx_b1", hrb1, e_hrb1);
    chk(dtag(m_mode), "hdlc_rx_b2", hrb2, e_hrb2);
    chk(dtag(m_mode), "hdlc_rx_d", hrd, e_hrd);
    chk((m_mode == 1) ? "R2" : "R8", "pcm_out_b1", pob1, e_pob1);
    chk((m_mode == 1) ? "R2" : "R8", "pcm_out_b2", pob2, e_pob2);
    chk((m_mode == 2) ? "R4" : bt, "l1_tx_b1", tb1, e_tb1);
    chk((m_mode == 2) ? "R4" : bt, "l1_tx_b2", tb2, e_tb2);
    chk((m_mode == 2) ? "R5" : bt, "l1_tx_d", trd, e_trd);
    chk("R9", "al_loop_o", alo, e_al);
    chk("R9", "l1_tx_en_o", ten, !e_al);
    chk("R10", "ind_o", ind, e_ind);
  endtask

  int lc = 0;
  task automatic step();
    @(negedge clk);
    if (rst_n) compare_all();
    lc = (lc == LP-1) ? 0 : lc + 1;
    l1f  = (lc == 0);
    l1b1 = (lc == 5);
    l1d  = (lc == 10) || (lc == 30);
    l1b2 = (lc == 15);
    rxb1 = B_W'($urandom); rxb2 = B_W'($urandom); rxd = 1'($urandom);
    txb1 = B_W'($urandom); txb2 = B_W'($urandom); txd = 1'($urandom);
    pb1  = B_W'($urandom); pb2  = B_W'($urandom);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "frame_o", fo, 0);
    chk("R11", "hdlc_rx_b1", hrb1, 255);
    chk("R11", "l1_tx_d", trd, 1);
    chk("R11", "ind_o", ind, 0);
    chk("R11", "l1_tx_en_o", ten, 1);
    chk("R11", "al_loop_o", alo, 0);
    rst_n = 1'b1;
    run(200);                                  // R8 normal
    dig = 1; run(300);                         // R1 R2 R3
    rem = 1; run(300);                         // R6 remote overrides digital
    dig = 0; run(200);                         // R4 R5
    rem = 0; run(120);
    for (int k = 0; k < 20; k++) begin         // R7 short pulses inside frames
      dig = 1; run(3); dig = 0; run(11);
    end
    dig = 1; run(150);
    dig = 0; run(150);
    ana = 1; run(10);                          // R9 R10
    lock = 1; run(10);
    awake = 1; run(10);
    lock = 0; run(10);
    awake = 0; run(10);
    ana = 0; lock = 1; awake = 1; run(10);     // R10 ignored without command
    lock = 0; awake = 0;
    rem = 1; ana = 1; lock = 1; run(200);
    rem = 0; ana = 0; lock = 0; run(100);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R11 act=timeout exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule